// File: doc/BRIEF.md
# Incremental PID Duty Compensator

This block turns a stream of error samples into the duty command of a switching power converter. Once per switching period a sample strobe delivers a new signed error word. The block then updates its duty state with an incremental second-order law that has an integrating pole: the new duty equals the previous duty plus a weighted sum of the present error and the two errors before it, with the weight of the one-sample-old error subtracted. Because the law is incremental, the duty state is itself the integrator. The equivalent transfer function is (b0·z² − b1·z + b2) / (z·(z − 1)).

The three weights come in on input ports as signed fixed-point words with 12 fractional bits. The duty state keeps those 12 fractional bits, so increments smaller than one duty step still add up over many periods. The state is held inside [0, DUTY_MAX] in duty units. The held value is the one kept for the next period, so the integrator cannot wind up past the limits. The integer part of the state goes out as the duty word to a digital PWM generator, together with a one-cycle valid strobe.

Top module: `pid_duty_comp`

## Requirements
- R1: After each sample, the internal state becomes S = Sprev + b0·e[n] − b1·e[n−1] + b2·e[n−2]. Coefficients are two's-complement with 12 fractional bits. S keeps 12 fractional bits, and duty_out equals floor(S / 4096) after limiting.
- R2: A sample presented with sample_valid at rising edge k produces duty_valid high for exactly the one cycle that follows edge k+1, with the new duty_out visible in that same cycle.
- R3: The state never exceeds DUTY_MAX·4096, so duty_out is never above DUTY_MAX.
- R4: The state never goes below zero, so a negative result gives duty_out = 0.
- R5: When a result is limited, the limited value is stored as the previous duty. A reverse error therefore moves the duty away from the limit at once.
- R6: A synchronous active-high reset clears both stored errors, the duty state, duty_out and duty_valid.
- R7: Cycles without sample_valid change neither duty_out nor the error history, and keep duty_valid low.
- R8: Samples on consecutive cycles are each processed in order, one result per cycle.
- R9: The one-sample-old error term enters with a negative sign: a negative b1 raises the duty one period after a positive error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | Strobe marking a new error sample |
| err_in | input | ERR_W | Signed error sample |
| coef_b0 | input | COEF_W | Weight of the present error, signed, 12 fractional bits |
| coef_b1 | input | COEF_W | Weight subtracted for the previous error, signed, 12 fractional bits |
| coef_b2 | input | COEF_W | Weight of the error two samples back, signed, 12 fractional bits |
| duty_out | output | DUTY_W | Limited duty word |
| duty_valid | output | 1 | One-cycle strobe marking a new duty word |

## Verification
The bench builds the block with its defaults: 10-bit errors, 18-bit coefficients with 12 fractional bits, a 32-bit accumulator and DUTY_MAX = 1000. The 18-bit coefficient width admits both of the stable weight sets, including one with b1 above 11. The limit of 1000 lets a single large error drive the state into either limit, so anti-windup release can be seen within a few samples. Unit-sized coefficient picks isolate the sign of each tap and the accumulation of fractional increments, and these checks use hand-computed values.

// File: rtl/pidc_pkg.sv
package pidc_pkg;

  // Number of error taps in the difference equation (present, one back, two back).
  localparam int TAPS = 3;

  typedef enum logic [1:0] {
    TAP_NOW  = 2'd0,
    TAP_ONE  = 2'd1,
    TAP_TWO  = 2'd2
  } tap_e;

  // The one-sample-old tap enters the sum with a negative sign.
  function automatic logic tap_negated(input int idx);
    return (idx == int'(TAP_ONE));
  endfunction

endpackage

// File: rtl/pidc_history.sv
module pidc_history #(
  parameter int ERR_W = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    shift_en,
  input  logic signed [ERR_W-1:0] err_now,
  output logic signed [ERR_W-1:0] err_d1,
  output logic signed [ERR_W-1:0] err_d2
);

  always_ff @(posedge clk) begin
    if (rst) begin
      err_d1 <= '0;
      err_d2 <= '0;
    end else if (shift_en) begin
      err_d1 <= err_now;
      err_d2 <= err_d1;
    end
  end

endmodule

// File: rtl/pidc_mac.sv
module pidc_mac
  import pidc_pkg::*;
#(
  parameter int ERR_W  = 10,
  parameter int COEF_W = 18,
  parameter int ACC_W  = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [ERR_W-1:0]  err_now,
  input  logic signed [ERR_W-1:0]  err_d1,
  input  logic signed [ERR_W-1:0]  err_d2,
  input  logic signed [COEF_W-1:0] c0,
  input  logic signed [COEF_W-1:0] c1,
  input  logic signed [COEF_W-1:0] c2,
  output logic signed [ACC_W-1:0]  inc_q,
  output logic                     inc_valid
);

  localparam int EXT_E = ACC_W - ERR_W;
  localparam int EXT_C = ACC_W - COEF_W;

  logic signed [ERR_W-1:0]  tap_err  [TAPS];
  logic signed [COEF_W-1:0] tap_coef [TAPS];
  logic signed [ACC_W-1:0]  term     [TAPS];
  logic signed [ACC_W-1:0]  sum_c;

  assign tap_err[0]  = err_now;
  assign tap_err[1]  = err_d1;
  assign tap_err[2]  = err_d2;
  assign tap_coef[0] = c0;
  assign tap_coef[1] = c1;
  assign tap_coef[2] = c2;

  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    logic signed [ACC_W-1:0] ext_e;
    logic signed [ACC_W-1:0] ext_c;
    logic signed [ACC_W-1:0] prod;
    assign ext_e = {{EXT_E{tap_err[i][ERR_W-1]}}, tap_err[i]};
    assign ext_c = {{EXT_C{tap_coef[i][COEF_W-1]}}, tap_coef[i]};
    assign prod  = ext_e * ext_c;
    if (tap_negated(i)) begin : g_neg
      assign term[i] = -prod;
    end else begin : g_pos
      assign term[i] = prod;
    end
  end

  always_comb begin
    sum_c = '0;
    for (int i = 0; i < TAPS; i++) begin
      sum_c = sum_c + term[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      inc_q     <= '0;
      inc_valid <= 1'b0;
    end else begin
      inc_valid <= in_valid;
      if (in_valid) begin
        inc_q <= sum_c;
      end
    end
  end

endmodule

// File: rtl/pidc_integ_clamp.sv
module pidc_integ_clamp #(
  parameter int ACC_W    = 32,
  parameter int FRAC     = 12,
  parameter int DUTY_W   = 10,
  parameter int DUTY_MAX = 1000
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    inc_valid,
  input  logic signed [ACC_W-1:0] inc,
  output logic [DUTY_W-1:0]       duty_out,
  output logic                    duty_valid
);

  localparam logic signed [ACC_W-1:0] MAX_FX = ACC_W'(DUTY_MAX * (2 ** FRAC));

  logic signed [ACC_W-1:0] state_q;
  logic signed [ACC_W-1:0] raw_c;
  logic signed [ACC_W-1:0] lim_c;

  assign raw_c = state_q + inc;

  always_comb begin
    if (raw_c < 0) begin
      lim_c = '0;
    end else if (raw_c > MAX_FX) begin
      lim_c = MAX_FX;
    end else begin
      lim_c = raw_c;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= '0;
      duty_out   <= '0;
      duty_valid <= 1'b0;
    end else begin
      duty_valid <= inc_valid;
      if (inc_valid) begin
        state_q  <= lim_c;
        duty_out <= lim_c[FRAC +: DUTY_W];
      end
    end
  end

endmodule

// File: rtl/pid_duty_comp.sv
module pid_duty_comp #(
  parameter int ERR_W    = 10,
  parameter int COEF_W   = 18,
  parameter int FRAC     = 12,
  parameter int ACC_W    = 32,
  parameter int DUTY_W   = 10,
  parameter int DUTY_MAX = 1000
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     sample_valid,
  input  logic signed [ERR_W-1:0]  err_in,
  input  logic signed [COEF_W-1:0] coef_b0,
  input  logic signed [COEF_W-1:0] coef_b1,
  input  logic signed [COEF_W-1:0] coef_b2,
  output logic [DUTY_W-1:0]        duty_out,
  output logic                     duty_valid
);

  logic signed [ERR_W-1:0] err_d1;
  logic signed [ERR_W-1:0] err_d2;
  logic signed [ACC_W-1:0] inc_q;
  logic                    inc_valid;

  pidc_history #(.ERR_W(ERR_W)) u_hist (
    .clk      (clk),
    .rst      (rst),
    .shift_en (sample_valid),
    .err_now  (err_in),
    .err_d1   (err_d1),
    .err_d2   (err_d2)
  );

  pidc_mac #(.ERR_W(ERR_W), .COEF_W(COEF_W), .ACC_W(ACC_W)) u_mac (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (sample_valid),
    .err_now   (err_in),
    .err_d1    (err_d1),
    .err_d2    (err_d2),
    .c0        (coef_b0),
    .c1        (coef_b1),
    .c2        (coef_b2),
    .inc_q     (inc_q),
    .inc_valid (inc_valid)
  );

  pidc_integ_clamp #(
    .ACC_W(ACC_W), .FRAC(FRAC), .DUTY_W(DUTY_W), .DUTY_MAX(DUTY_MAX)
  ) u_clamp (
    .clk        (clk),
    .rst        (rst),
    .inc_valid  (inc_valid),
    .inc        (inc_q),
    .duty_out   (duty_out),
    .duty_valid (duty_valid)
  );

endmodule

// File: rtl/pidc_checker.sv
module pidc_checker #(
  parameter int DUTY_W   = 10,
  parameter int DUTY_MAX = 1000
) (
  input logic              clk,
  input logic              rst,
  input logic              sample_valid,
  input logic [DUTY_W-1:0] duty_out,
  input logic              duty_valid
);

  logic [1:0] age_q;
  logic       rst_d;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst) age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  // R2: result strobe follows the sample strobe by two edges
  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    (age_q >= 2'd2) |-> (duty_valid == $past(sample_valid, 2)));

  // R3: duty word never above the upper limit
  p_upper_limit_r3: assert property (@(posedge clk) disable iff (rst)
    duty_out <= DUTY_W'(DUTY_MAX));

  // R7: without a result strobe the duty word holds
  p_hold_idle_r7: assert property (@(posedge clk) disable iff (rst)
    ((age_q >= 2'd1) && !duty_valid) |-> $stable(duty_out));

  // R6: outputs cleared in the cycle after reset
  always_ff @(posedge clk) begin
    if (rst_d === 1'b1) begin
      p_reset_clear_r6: assert (duty_out == '0 && !duty_valid);
    end
  end

endmodule

bind pid_duty_comp pidc_checker #(.DUTY_W(DUTY_W), .DUTY_MAX(DUTY_MAX)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .sample_valid (sample_valid),
  .duty_out     (duty_out),
  .duty_valid   (duty_valid)
);

// File: tb/tb_pid_duty_comp.sv
module tb_pid_duty_comp;

  localparam int ERR_W = 10, COEF_W = 18, DUTY_W = 10, DUTY_MAX = 1000;
  localparam longint ONE = 4096;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sample_valid = 1'b0;
  logic signed [ERR_W-1:0]  err_in = '0;
  logic signed [COEF_W-1:0] coef_b0 = '0, coef_b1 = '0, coef_b2 = '0;
  logic [DUTY_W-1:0] duty_out;
  logic duty_valid;

  int n_run = 0, n_fail = 0;
  longint m_e1 = 0, m_e2 = 0, m_s = 0;

  always #10 clk = ~clk;

  pid_duty_comp dut (
    .clk(clk), .rst(rst), .sample_valid(sample_valid), .err_in(err_in),
    .coef_b0(coef_b0), .coef_b1(coef_b1), .coef_b2(coef_b2),
    .duty_out(duty_out), .duty_valid(duty_valid)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint model_step(input longint e);
    longint s;
    s = m_s + longint'(coef_b0) * e - longint'(coef_b1) * m_e1 + longint'(coef_b2) * m_e2;
    if (s < 0) s = 0;
    if (s > DUTY_MAX * ONE) s = DUTY_MAX * ONE;
    m_s = s; m_e2 = m_e1; m_e1 = e;
    return s / ONE;
  endfunction

  task automatic set_coef(input longint b0, input longint b1, input longint b2);
    coef_b0 = COEF_W'(b0); coef_b1 = COEF_W'(b1); coef_b2 = COEF_W'(b2);
  endtask

  // R6: reset pulse, then outputs are cleared
  task automatic do_reset();
    @(negedge clk); rst = 1'b1; sample_valid = 1'b0;
    @(negedge clk); rst = 1'b0;
    m_e1 = 0; m_e2 = 0; m_s = 0;
    check("R6 duty after reset", duty_out, 0);
    check("R6 valid after reset", duty_valid, 0);
  endtask

  // One sample; result checked two edges later, in the stated cycle.
  task automatic push(input string req, input longint e, output longint got);
    longint exp;
    @(negedge clk); err_in = ERR_W'(e); sample_valid = 1'b1;
    exp = model_step(e);
    @(negedge clk); sample_valid = 1'b0;
    @(negedge clk);
    check({req, " valid"}, duty_valid, 1);
    check({req, " duty"}, duty_out, exp);
    got = duty_out;
  endtask

  task automatic t_latency();
    longint exp;
    do_reset();
    set_coef(ONE, 0, 0);
    @(negedge clk); err_in = 10'sd20; sample_valid = 1'b1;
    exp = model_step(20);
    @(negedge clk); sample_valid = 1'b0;
    check("R2 no valid after first edge", duty_valid, 0);
    @(negedge clk);
    check("R2 valid after second edge", duty_valid, 1);
    check("R2 duty value", duty_out, exp);
    @(negedge clk);
    check("R2 valid is one cycle", duty_valid, 0);
  endtask

  task automatic t_fraction();
    longint g;
    do_reset();
    set_coef(1024, 0, 0);  // 0.25
    push("R1 frac 1", 1, g); check("R1 frac hand 1", g, 0);
    push("R1 frac 2", 1, g);
    push("R1 frac 3", 1, g); check("R1 frac hand 3", g, 0);
    push("R1 frac 4", 1, g); check("R1 frac hand 4", g, 1);
  endtask

  task automatic t_taps();
    longint g;
    do_reset();
    set_coef(0, -2 * ONE, 0);
    push("R9 b1 first", 50, g); check("R9 hand first", g, 0);
    push("R9 b1 second", 0, g); check("R9 hand second", g, 100);
    do_reset();
    set_coef(0, 0, 3 * ONE);
    push("R1 b2 a", 7, g);
    push("R1 b2 b", 0, g); check("R1 b2 hand b", g, 0);
    push("R1 b2 c", 0, g); check("R1 b2 hand c", g, 21);
  endtask

  task automatic t_limits();
    longint g;
    do_reset();
    set_coef(10 * ONE, 0, 0);
    push("R3 high", 500, g); check("R3 hand high", g, DUTY_MAX);
    push("R3 high again", 300, g); check("R3 hand held", g, DUTY_MAX);
    push("R5 release", -1, g); check("R5 hand release", g, 990);
    push("R4 low", -500, g); check("R4 hand low", g, 0);
    push("R4 from zero", 3, g); check("R4 hand rise", g, 30);
  endtask

  task automatic t_idle();
    longint g, held;
    do_reset();
    set_coef(6144, 11328, 5208);
    push("R1 set1 a", 200, g);
    push("R1 set1 b", 150, g);
    held = duty_out;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      err_in = 10'sd400;
      check("R7 idle valid", duty_valid, 0);
      check("R7 idle duty", duty_out, held);
    end
    push("R7 history kept", 100, g);
    push("R1 set1 c", -40, g);
  endtask

  task automatic t_burst();
    longint e1, e2, e3;
    do_reset();
    set_coef(24699, 46681, 22009);
    @(negedge clk); err_in = 10'sd30; sample_valid = 1'b1; e1 = model_step(30);
    @(negedge clk); err_in = 10'sd10; e2 = model_step(10);
    @(negedge clk); err_in = -10'sd5; e3 = model_step(-5);
    check("R8 first", duty_out, e1); check("R8 first valid", duty_valid, 1);
    @(negedge clk); sample_valid = 1'b0;
    check("R8 second", duty_out, e2); check("R8 second valid", duty_valid, 1);
    @(negedge clk);
    check("R8 third", duty_out, e3); check("R8 third valid", duty_valid, 1);
    @(negedge clk);
    check("R8 end valid", duty_valid, 0);
  endtask

  task automatic t_midreset();
    longint g;
    do_reset();
    set_coef(ONE, 5 * ONE, 0);
    push("R6 pre a", 100, g);
    push("R6 pre b", 100, g);
    do_reset();
    push("R6 history cleared", 8, g); check("R6 hand", g, 8);
  endtask

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    t_latency();
    t_fraction();
    t_taps();
    t_limits();
    t_idle();
    t_burst();
    t_midreset();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule